// File: doc/BRIEF.md
# Predicated Vector Element Issue Unit

This unit sits between instruction decode and a multi-issue instruction FIFO. It turns one scalar-format instruction into a run of per-element instructions. A tag table, held in a set of control bits, marks each architectural register as scalar or vectorised. Each element is a copy of the accepted instruction. In every vectorised operand field the register number is raised by the element index, while scalar fields keep their number. The element index itself travels with each element. The program counter stays put until the run is complete, and a one-cycle `done` pulse tells the fetch side that it may advance.

Predication uses a mask held in an ordinary integer register, which the operands can also target. A write to that register may still be in flight, so the unit behaves as a hazard-tracked consumer. It presents the mask register number to the register file and waits until the dependency tracker stops flagging it as busy. Only then does it capture the mask. From that point it walks the elements and drops every element whose mask bit is clear. Unpredicated instructions use an all-ones mask and start issuing at once.

Top module: `vec_elem_issue`

## Requirements
- R1: After reset `in_ready` is 1, `fifo_valid` and `done` are 0, and every register is tagged scalar.
- R2: An accepted instruction with effective length N produces elements with `fifo_idx` 0 to N-1 in increasing order, each carrying the accepted opcode, with no element pushed twice.
- R3: For element i, each operand field whose register is tagged vectorised (tag bit sampled when the instruction is accepted) reads base+i modulo NREG; scalar-tagged fields read the base number unchanged.
- R4: A predicated instruction drives its mask register number on `pred_rd_addr` and pushes nothing and raises no `done` while `pred_busy` is 1. The mask is sampled from `pred_rd_data` in the first cycle that `pred_busy` is 0.
- R5: Element i is pushed only when bit i of the captured mask is 1; an unpredicated instruction uses a mask of all ones.
- R6: While `fifo_valid` is 1 and `fifo_ready` is 0, the unit holds `fifo_valid` and the whole element payload stable and does not move to the next element.
- R7: `done` is high for exactly one cycle, in the cycle where the last element is pushed or skipped. `in_ready` is 0 from the cycle after acceptance until that point, and 1 again in the cycle after `done`.
- R8: A length of 0 or 1 yields a single element with index 0 and the base register numbers, still subject to mask bit 0. A length above XLEN is clamped to XLEN.
- R9: An instruction whose active mask bits are all 0 pushes nothing yet still completes with one `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tag_we | input | 1 | Write strobe for the register tag table |
| tag_idx | input | RW | Register whose tag is written |
| tag_vec | input | 1 | New tag: 1 vectorised, 0 scalar |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Unit idle and able to accept |
| in_opcode | input | OPW | Opcode of the offered instruction |
| in_rd | input | RW | Destination register |
| in_rs1 | input | RW | First source register |
| in_rs2 | input | RW | Second source register |
| in_pred_en | input | 1 | Instruction is predicated |
| in_pred_reg | input | RW | Register holding the predicate mask |
| in_vl | input | VLW | Vector length |
| pred_rd_addr | output | RW | Register file read address for the mask |
| pred_rd_data | input | XLEN | Mask value read from the register file |
| pred_busy | input | 1 | Dependency tracker: mask register has a pending write |
| fifo_valid | output | 1 | Element offered to the instruction FIFO |
| fifo_ready | input | 1 | FIFO accepts the element |
| fifo_opcode | output | OPW | Element opcode |
| fifo_rd | output | RW | Element destination register |
| fifo_rs1 | output | RW | Element first source register |
| fifo_rs2 | output | RW | Element second source register |
| fifo_idx | output | IW | Element index |
| done | output | 1 | Last element handled; program counter may advance |

## Verification
The bench holds `pred_busy` high for several cycles after a predicated instruction is accepted. A unit that ignored the hazard would push elements using a stale mask. It also uses a sparse mask and a fully cleared mask, which catch an off-by-one in bit selection and a missing `done` when nothing is pushed. FIFO stalls are tested both with a long stall on the first element and with a busy/free pattern; a unit that advanced on a stall would skip or repeat indices. The bench also covers register numbers that wrap past the top of the file, lengths of 0 and 1 with a cleared bit 0, and a length above the mask width, which a unit without clamping would run past the mask.

// File: rtl/vec_elem_issue.sv
module vec_elem_issue #(
  parameter int NREG = 32,
  parameter int XLEN = 32,
  parameter int OPW  = 7,
  parameter int VLW  = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tag_we,
  input  logic [$clog2(NREG)-1:0]   tag_idx,
  input  logic                      tag_vec,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [OPW-1:0]            in_opcode,
  input  logic [$clog2(NREG)-1:0]   in_rd,
  input  logic [$clog2(NREG)-1:0]   in_rs1,
  input  logic [$clog2(NREG)-1:0]   in_rs2,
  input  logic                      in_pred_en,
  input  logic [$clog2(NREG)-1:0]   in_pred_reg,
  input  logic [VLW-1:0]            in_vl,
  output logic [$clog2(NREG)-1:0]   pred_rd_addr,
  input  logic [XLEN-1:0]           pred_rd_data,
  input  logic                      pred_busy,
  output logic                      fifo_valid,
  input  logic                      fifo_ready,
  output logic [OPW-1:0]            fifo_opcode,
  output logic [$clog2(NREG)-1:0]   fifo_rd,
  output logic [$clog2(NREG)-1:0]   fifo_rs1,
  output logic [$clog2(NREG)-1:0]   fifo_rs2,
  output logic [$clog2(XLEN)-1:0]   fifo_idx,
  output logic                      done
);
  localparam int RW = $clog2(NREG);
  localparam int IW = $clog2(XLEN);

  typedef enum logic [1:0] {S_IDLE = 2'd0, S_WAIT = 2'd1, S_RUN = 2'd2} st_t;
  st_t st;

  logic [NREG-1:0] vtag;
  logic [OPW-1:0]  op_q;
  logic [RW-1:0]   rd_q, rs1_q, rs2_q, pr_q;
  logic            vrd, vrs1, vrs2;
  logic [IW-1:0]   idx_q, last_q, last_in;
  logic [XLEN-1:0] mask_q;
  logic            cur_bit, step, accept;

  always_comb begin
    if (in_vl == '0)
      last_in = '0;
    else if (int'(in_vl) > XLEN)
      last_in = IW'(XLEN - 1);
    else
      last_in = IW'(in_vl - 1'b1);
  end

  assign accept       = in_valid && in_ready;
  assign in_ready     = (st == S_IDLE);
  assign cur_bit      = mask_q[idx_q];
  assign fifo_valid   = (st == S_RUN) && cur_bit;
  assign step         = (st == S_RUN) && (!cur_bit || fifo_ready);
  assign done         = step && (idx_q == last_q);
  assign pred_rd_addr = pr_q;
  assign fifo_opcode  = op_q;
  assign fifo_idx     = idx_q;
  assign fifo_rd      = vrd  ? rd_q  + RW'(idx_q) : rd_q;
  assign fifo_rs1     = vrs1 ? rs1_q + RW'(idx_q) : rs1_q;
  assign fifo_rs2     = vrs2 ? rs2_q + RW'(idx_q) : rs2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      vtag   <= '0;
      op_q   <= '0;
      rd_q   <= '0;
      rs1_q  <= '0;
      rs2_q  <= '0;
      pr_q   <= '0;
      vrd    <= 1'b0;
      vrs1   <= 1'b0;
      vrs2   <= 1'b0;
      idx_q  <= '0;
      last_q <= '0;
      mask_q <= '0;
    end else begin
      if (tag_we) vtag[tag_idx] <= tag_vec;
      case (st)
        S_IDLE: if (accept) begin
          op_q   <= in_opcode;
          rd_q   <= in_rd;
          rs1_q  <= in_rs1;
          rs2_q  <= in_rs2;
          pr_q   <= in_pred_reg;
          vrd    <= vtag[in_rd];
          vrs1   <= vtag[in_rs1];
          vrs2   <= vtag[in_rs2];
          idx_q  <= '0;
          last_q <= last_in;
          mask_q <= '1;
          st     <= in_pred_en ? S_WAIT : S_RUN;
        end
        S_WAIT: if (!pred_busy) begin
          mask_q <= pred_rd_data;
          st     <= S_RUN;
        end
        S_RUN: if (step) begin
          if (idx_q == last_q) st <= S_IDLE;
          else idx_q <= idx_q + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module vec_elem_issue_chk #(
  parameter int RW   = 5,
  parameter int IW   = 5,
  parameter int OPW  = 7,
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic            fifo_valid,
  input logic            fifo_ready,
  input logic [OPW-1:0]  fifo_opcode,
  input logic [RW-1:0]   fifo_rd,
  input logic [RW-1:0]   fifo_rs1,
  input logic [RW-1:0]   fifo_rs2,
  input logic [IW-1:0]   fifo_idx,
  input logic            done,
  input logic [1:0]      st,
  input logic [IW-1:0]   last_q,
  input logic [XLEN-1:0] mask_q
);
  always @(negedge clk)
    if (!rst_n) a_r1_reset_quiet: assert (in_ready && !fifo_valid && !done);

  a_r6_hold_payload: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_valid && !fifo_ready |=> fifo_valid &&
      $stable({fifo_opcode, fifo_rd, fifo_rs1, fifo_rs2, fifo_idx}));

  a_r4_wait_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    st == 2'd1 |-> !fifo_valid && !done);

  a_r7_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready);

  a_r7_done_release: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> in_ready && !done);

  a_r5_pred_bit: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_valid |-> mask_q[fifo_idx]);

  a_r2_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_valid |-> fifo_idx <= last_q);
endmodule

bind vec_elem_issue vec_elem_issue_chk #(.RW(RW), .IW(IW), .OPW(OPW), .XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .fifo_valid(fifo_valid), .fifo_ready(fifo_ready), .fifo_opcode(fifo_opcode),
  .fifo_rd(fifo_rd), .fifo_rs1(fifo_rs1), .fifo_rs2(fifo_rs2), .fifo_idx(fifo_idx),
  .done(done), .st(st), .last_q(last_q), .mask_q(mask_q));

// File: tb/vec_elem_issue_tb.sv
module vec_elem_issue_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic tag_we = 0, tag_vec = 0;
  logic [4:0] tag_idx = 0;
  logic in_valid = 0, in_pred_en = 0;
  logic in_ready;
  logic [6:0] in_opcode = 0;
  logic [4:0] in_rd = 0, in_rs1 = 0, in_rs2 = 0, in_pred_reg = 0;
  logic [5:0] in_vl = 0;
  logic [4:0] pred_rd_addr;
  logic [31:0] pred_rd_data = 0;
  logic pred_busy = 0;
  logic fifo_valid, fifo_ready = 1, done;
  logic [6:0] fifo_opcode;
  logic [4:0] fifo_rd, fifo_rs1, fifo_rs2, fifo_idx;

  vec_elem_issue u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0, fails = 0, n_push = 0, n_done = 0, cyc = 0;
  bit bp_mode = 0;
  int l_op[64], l_rd[64], l_rs1[64], l_rs2[64], l_idx[64];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && fifo_valid && fifo_ready && n_push < 64) begin
      l_op[n_push] = fifo_opcode; l_rd[n_push] = fifo_rd; l_rs1[n_push] = fifo_rs1;
      l_rs2[n_push] = fifo_rs2; l_idx[n_push] = fifo_idx;
      n_push = n_push + 1;
    end
    if (rst_n && done) n_done = n_done + 1;
  end

  always @(negedge clk) if (bp_mode) fifo_ready = (cyc % 3) != 1;

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_tag(input int r, input bit v);
    @(negedge clk); tag_we = 1; tag_idx = 5'(r); tag_vec = v;
    @(negedge clk); tag_we = 0;
  endtask

  task automatic issue(input int op, input int rd, input int rs1, input int rs2,
                       input bit pe, input int pr, input int vl);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    n_push = 0;
    in_valid = 1; in_opcode = 7'(op); in_rd = 5'(rd); in_rs1 = 5'(rs1); in_rs2 = 5'(rs2);
    in_pred_en = pe; in_pred_reg = 5'(pr); in_vl = 6'(vl);
    @(negedge clk); in_valid = 0;
  endtask

  task automatic wait_done(input int start);
    for (int k = 0; k < 400 && n_done == start; k++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R7 done pulse count", n_done - start, 1);
    chk("R7 in_ready after done", int'(in_ready), 1);
  endtask

  task automatic t_reset;
    chk("R1 in_ready", int'(in_ready), 1);
    chk("R1 fifo_valid", int'(fifo_valid), 0);
    chk("R1 done", int'(done), 0);
    issue(3, 4, 8, 9, 0, 0, 2);
    wait_done(0);
    chk("R1 rd scalar after reset", l_rd[1], 4);
    chk("R1 rs1 scalar after reset", l_rs1[1], 8);
  endtask

  task automatic t_unpred;
    int s;
    set_tag(4, 1); set_tag(8, 1);
    s = n_done;
    issue(21, 4, 8, 9, 0, 0, 4);
    chk("R7 in_ready low while busy", int'(in_ready), 0);
    wait_done(s);
    chk("R2 push count", n_push, 4);
    for (int i = 0; i < 4; i++) begin
      chk("R2 index", l_idx[i], i);
      chk("R2 opcode", l_op[i], 21);
      chk("R3 vec rd", l_rd[i], 4 + i);
      chk("R3 vec rs1", l_rs1[i], 8 + i);
      chk("R3 scalar rs2", l_rs2[i], 9);
    end
  endtask

  task automatic t_pred_wait;
    int s, exp_i[4];
    exp_i = '{1, 2, 5, 7};
    s = n_done;
    pred_busy = 1; pred_rd_data = 32'h0000_00FF;
    issue(5, 4, 1, 2, 1, 3, 8);
    repeat (5) @(negedge clk);
    chk("R4 mask address", int'(pred_rd_addr), 3);
    chk("R4 no push while busy", n_push, 0);
    chk("R4 no done while busy", n_done - s, 0);
    pred_rd_data = 32'h0000_00A6;
    pred_busy = 0;
    wait_done(s);
    chk("R5 sparse push count", n_push, 4);
    for (int i = 0; i < 4; i++) begin
      chk("R5 kept index", l_idx[i], exp_i[i]);
      chk("R3 rd follows index", l_rd[i], 4 + exp_i[i]);
    end
  endtask

  task automatic t_backpressure;
    int s;
    s = n_done;
    fifo_ready = 0;
    issue(9, 8, 0, 4, 0, 0, 6);
    repeat (3) @(negedge clk);
    chk("R6 valid held in stall", int'(fifo_valid), 1);
    chk("R6 index held in stall", int'(fifo_idx), 0);
    chk("R6 nothing taken in stall", n_push, 0);
    bp_mode = 1;
    wait_done(s);
    bp_mode = 0; fifo_ready = 1;
    chk("R6 push count", n_push, 6);
    for (int i = 0; i < 6; i++) begin
      chk("R6 order no dup", l_idx[i], i);
      chk("R3 rs2 vec", l_rs2[i], 4 + i);
    end
  endtask

  task automatic t_short;
    int s;
    s = n_done; pred_rd_data = 32'hFFFF_FFFE;
    issue(1, 4, 8, 9, 1, 6, 1);
    wait_done(s);
    chk("R8 vl1 bit0 clear dropped", n_push, 0);
    s = n_done; pred_rd_data = 32'h0000_0001;
    issue(2, 4, 8, 9, 1, 6, 1);
    wait_done(s);
    chk("R8 vl1 one push", n_push, 1);
    chk("R8 vl1 rd unchanged", l_rd[0], 4);
    chk("R8 vl1 rs1 unchanged", l_rs1[0], 8);
    s = n_done;
    issue(3, 4, 8, 9, 0, 0, 0);
    wait_done(s);
    chk("R8 vl0 one push", n_push, 1);
    chk("R8 vl0 index", l_idx[0], 0);
  endtask

  task automatic t_all_masked;
    int s;
    s = n_done; pred_rd_data = 32'hFFFF_FFE0;
    issue(7, 4, 8, 9, 1, 2, 5);
    wait_done(s);
    chk("R9 nothing pushed", n_push, 0);
  endtask

  task automatic t_wrap_clamp;
    int s;
    set_tag(30, 1);
    s = n_done;
    issue(4, 30, 1, 2, 0, 0, 4);
    wait_done(s);
    chk("R3 wrap count", n_push, 4);
    for (int i = 0; i < 4; i++) chk("R3 wrap rd", l_rd[i], (30 + i) % 32);
    s = n_done;
    issue(6, 10, 1, 2, 0, 0, 40);
    wait_done(s);
    chk("R8 clamp count", n_push, 32);
    chk("R8 clamp last index", l_idx[31], 31);
    chk("R2 clamp first opcode", l_op[0], 6);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_pre();
  end

  task automatic t_reset_pre;
    chk("R1 in_ready in reset", int'(in_ready), 1);
    chk("R1 fifo_valid in reset", int'(fifo_valid), 0);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_unpred();
    t_pred_wait();
    t_backpressure();
    t_short();
    t_all_masked();
    t_wrap_clamp();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask
endmodule